// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block runs the bus handshake that pulls an interrupt vector out of an external cascaded interrupt controller. When the interrupt control logic raises an acknowledge request, the sequencer drives two acknowledge bus cycles back to back. Each cycle has the shape of a read cycle: an address latch enable phase, two strobe phases and a closing phase, with wait states added while the ready input is low. The acknowledge strobe takes the place of the read strobe.

A bus lock output stays high across both cycles so that no other master can split the pair. The first cycle only alerts the controller and no data is taken from it. In the second cycle the vector is taken from the low byte lane of the 16-bit data bus, and the upper lane is ignored. When the pair completes, the byte is offered to the processor core together with a one-clock valid pulse.

Top module: `iack_sequencer`

## Requirements
- R1: While reset is low at a clock edge, the outputs settle to inta_n_o = 1, lock_o = 0, ale_o = 0, vec_valid_o = 0 and vec_o = 0.
- R2: A request seen in the idle state at a clock edge starts the first cycle in the next clock. Every acknowledge cycle opens with exactly one clock of ale_o high, so one acknowledge gives exactly two ALE pulses.
- R3: lock_o rises with the first ALE clock. It stays high without a break through the last clock of the second cycle and is low while idle.
- R4: In each cycle, inta_n_o is low during the second and third clocks and during any wait clocks. It is high during the ALE clock and the closing clock.
- R5: When ready is low at the end of the third clock or of a wait clock, another wait clock is inserted with inta_n_o held low. With N wait clocks in the first cycle and M in the second, inta_n_o is low for 4 + N + M clocks. Ready is ignored in all other clocks.
- R6: The vector is taken from data bits 7:0 at the edge that ends the second cycle's strobe (ready high). Bits 15:8 and all data seen in the first cycle have no effect on vec_o.
- R7: vec_valid_o is high for exactly one clock, the clock after the closing clock of the second cycle, when lock_o is already low. vec_o keeps its value until the next capture.
- R8: A request held or raised while a sequence is in progress does not start a new one or lengthen the current one. A request present during the vec_valid_o clock is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ack_req_i | input | 1 | Acknowledge request from the interrupt control logic |
| data_i | input | 16 | Data bus input |
| ready_i | input | 1 | Bus ready; low inserts wait clocks |
| inta_n_o | output | 1 | Acknowledge strobe, active low |
| lock_o | output | 1 | Bus lock across both cycles |
| ale_o | output | 1 | Address latch enable |
| vec_valid_o | output | 1 | One-clock pulse when the vector is available |
| vec_o | output | 8 | Captured vector byte |

## Verification
If the phase register drifts, the fault shows at the pins within one clock. The strobe pattern or the ALE position then stops matching the reference, because the outputs decode directly from that state. If the cycle index is wrong, the sequence has one ALE pulse or three instead of two. It may also drop lock too early, or fire the valid pulse after the first cycle, which shows by the fifth clock of the sequence. A wrong capture point takes a byte from the first cycle or from the upper lane. Because every test drives different values into those lanes, the fault appears at vec_o in the valid-pulse clock.

// File: rtl/iack_pkg.sv
// Package: shared types for the interrupt acknowledge sequencer.
// Assumes: one phase value per base clock of an acknowledge bus cycle.
package iack_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } iack_phase_e;

endpackage

// File: rtl/iack_phase_ctrl.sv
// Module: iack_phase_ctrl
// Steps through ACK_CYCLES acknowledge bus cycles. Each cycle is T1, T2, T3,
// zero or more TW, then T4. A cycle leaves T3/TW only when ready is high.
// Assumes: the request is sampled only in PH_IDLE and ignored otherwise.
module iack_phase_ctrl
    import iack_pkg::*;
#(
    parameter int ACK_CYCLES = 2
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          req_i,
    input  logic                                          ready_i,
    output iack_phase_e                                   phase_o,
    output logic [((ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1)-1:0] cyc_o,
    output logic                                          last_cyc_o,
    output logic                                          sample_o,
    output logic                                          done_o
);

    localparam int IDX_W = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ACK_CYCLES - 1);

    iack_phase_e      phase_q, phase_d;
    logic [IDX_W-1:0] cyc_q, cyc_d;

    // Next phase and cycle index for the current phase and inputs.
    always_comb begin
        phase_d = phase_q;
        cyc_d   = cyc_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_i) begin
                    phase_d = PH_T1;
                    cyc_d   = '0;
                end
            end
            PH_T1: phase_d = PH_T2;
            PH_T2: phase_d = PH_T3;
            PH_T3, PH_TW: phase_d = ready_i ? PH_T4 : PH_TW;
            PH_T4: begin
                if (cyc_q == LAST_IDX) begin
                    phase_d = PH_IDLE;
                end else begin
                    phase_d = PH_T1;
                    cyc_d   = cyc_q + IDX_W'(1);
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase and cycle index registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cyc_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cyc_q   <= cyc_d;
        end
    end

    // Status derived from the registered phase.
    always_comb begin
        phase_o    = phase_q;
        cyc_o      = cyc_q;
        last_cyc_o = (cyc_q == LAST_IDX);
        sample_o   = ((phase_q == PH_T3) || (phase_q == PH_TW)) && ready_i;
        done_o     = (phase_q == PH_T4) && (cyc_q == LAST_IDX);
    end

    // R5: ready low at the end of a strobe clock adds a wait clock.
    a_r5_wait_inserted: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_T3) || (phase_q == PH_TW)) && !ready_i |=> (phase_q == PH_TW));

    // R8: the closing clock of the last cycle always returns to idle.
    a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_T4) && (cyc_q == LAST_IDX) |=> (phase_q == PH_IDLE));

    // R2: a request seen while idle opens the first cycle next clock.
    a_r2_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) && req_i |=> (phase_q == PH_T1) && (cyc_q == '0));

endmodule

// File: rtl/iack_vector_capture.sv
// Module: iack_vector_capture
// Holds the vector byte from the low lane of the data bus and raises a
// one-clock valid flag after the sequence's closing clock.
// Assumes: sample_i is high only in the capturing cycle's last strobe clock.
module iack_vector_capture #(
    parameter int DATA_W = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic              valid_o
);

    localparam int LANE_W = (VEC_W < DATA_W) ? VEC_W : DATA_W;

    logic [VEC_W-1:0] vec_q;
    logic             valid_q;
    logic [VEC_W-1:0] lane_low;

    // Select the low byte lane; zero-extend if the bus is narrower.
    generate
        if (LANE_W == VEC_W) begin : g_full_lane
            assign lane_low = data_i[VEC_W-1:0];
        end else begin : g_narrow_lane
            assign lane_low = {{(VEC_W-LANE_W){1'b0}}, data_i[LANE_W-1:0]};
        end
    endgenerate

    // Vector register and valid pulse with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (sample_i) begin
                vec_q <= lane_low;
            end
            valid_q <= done_i;
        end
    end

    assign vec_o   = vec_q;
    assign valid_o = valid_q;

    // R6: the vector changes only on a capture strobe.
    a_r6_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(vec_q));

endmodule

// File: rtl/iack_strobe_decode.sv
// Module: iack_strobe_decode
// Turns the registered phase into the bus control outputs.
// Assumes: phase comes straight from a register, so the outputs do not glitch.
module iack_strobe_decode
    import iack_pkg::*;
(
    input  iack_phase_e phase_i,
    output logic        ale_o,
    output logic        inta_n_o,
    output logic        lock_o
);

    // Output decode per phase.
    always_comb begin
        ale_o    = (phase_i == PH_T1);
        inta_n_o = !((phase_i == PH_T2) || (phase_i == PH_T3) || (phase_i == PH_TW));
        lock_o   = (phase_i != PH_IDLE);
    end

endmodule

// File: rtl/iack_sequencer.sv
// Module: iack_sequencer (top)
// Runs two locked acknowledge bus cycles per request and takes the vector
// from the low data lane in the second cycle.
// Assumes: ack_req_i, ready_i and data_i are synchronous to clk.
module iack_sequencer
    import iack_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int VEC_W      = 8,
    parameter int ACK_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_req_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ready_i,
    output logic              inta_n_o,
    output logic              lock_o,
    output logic              ale_o,
    output logic              vec_valid_o,
    output logic [VEC_W-1:0]  vec_o
);

    localparam int IDX_W = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;

    iack_phase_e      phase;
    logic [IDX_W-1:0] cyc;
    logic             last_cyc;
    logic             sample;
    logic             done;
    logic             capture_en;

    iack_phase_ctrl #(.ACK_CYCLES(ACK_CYCLES)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (ack_req_i),
        .ready_i    (ready_i),
        .phase_o    (phase),
        .cyc_o      (cyc),
        .last_cyc_o (last_cyc),
        .sample_o   (sample),
        .done_o     (done)
    );

    // Capture only in the final cycle of the sequence.
    assign capture_en = sample && last_cyc;

    iack_vector_capture #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (capture_en),
        .done_i   (done),
        .data_i   (data_i),
        .vec_o    (vec_o),
        .valid_o  (vec_valid_o)
    );

    iack_strobe_decode u_decode (
        .phase_i  (phase),
        .ale_o    (ale_o),
        .inta_n_o (inta_n_o),
        .lock_o   (lock_o)
    );

    // R3: the strobe is never active without the bus lock.
    a_r3_lock_covers_inta: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_o |-> lock_o);

    // R4: address latch and acknowledge strobe never overlap.
    a_r4_ale_not_with_inta: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> inta_n_o);

    // R7: the valid flag lasts a single clock.
    a_r7_valid_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

    // R7: the valid flag follows the release of the bus lock.
    a_r7_valid_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> !lock_o && $past(lock_o));

endmodule

// File: tb/iack_sequencer_tb.sv
// Bench for iack_sequencer: behavioural reference model compared every clock.
module iack_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack_req = 1'b0;
    logic [15:0] data_in = 16'h0000;
    logic        ready = 1'b1;
    logic        inta_n, lock, ale, vec_valid;
    logic [7:0]  vec;

    int checks = 0;
    int fails  = 0;

    // Reference model state: 0 idle, 1..4 base clocks, 5 wait clock.
    int       m_st = 0;
    int       m_cyc = 0;
    logic [7:0] m_vec = 8'h00;
    bit       m_valid = 1'b0;

    // Stimulus configuration.
    int         w_cfg [2];
    logic [7:0] lo_cfg [2];
    int         w_left = 0;
    int         inta_cnt = 0;
    int         ale_cnt = 0;
    bit         started = 1'b0;

    always #5 clk = ~clk;

    iack_sequencer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_req_i   (ack_req),
        .data_i      (data_in),
        .ready_i     (ready),
        .inta_n_o    (inta_n),
        .lock_o      (lock),
        .ale_o       (ale),
        .vec_valid_o (vec_valid),
        .vec_o       (vec)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model advanced at each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_st <= 0; m_cyc <= 0; m_vec <= 8'h00; m_valid <= 1'b0;
        end else begin
            m_valid <= 1'b0;
            case (m_st)
                0: if (ack_req) begin m_st <= 1; m_cyc <= 0; end
                1: m_st <= 2;
                2: m_st <= 3;
                3, 5: begin
                    if (ready) begin
                        m_st <= 4;
                        if (m_cyc == 1) m_vec <= data_in[7:0];
                    end else m_st <= 5;
                end
                4: begin
                    if (m_cyc == 1) begin m_st <= 0; m_valid <= 1'b1; end
                    else begin m_st <= 1; m_cyc <= 1; end
                end
                default: m_st <= 0;
            endcase
        end
    end

    // Bus-side driver and per-clock comparison on the falling edge.
    always @(negedge clk) begin
        if (started) begin
            check("R2", "ale", int'(ale), int'(m_st == 1));
            check("R3", "lock", int'(lock), int'(m_st != 0));
            check("R4", "inta_n", int'(inta_n), int'(!(m_st == 2 || m_st == 3 || m_st == 5)));
            check("R7", "vec_valid", int'(vec_valid), int'(m_valid));
            check("R6", "vec", int'(vec), int'(m_vec));
            if (!inta_n) inta_cnt++;
            if (ale) ale_cnt++;
        end
        if (m_st == 1) w_left = w_cfg[m_cyc];
        if (m_st == 3 || m_st == 5) begin
            if (w_left > 0) begin ready = 1'b0; w_left--; end
            else ready = 1'b1;
        end else begin
            ready = 1'($urandom % 2);
        end
        data_in = {8'($urandom), (m_st == 0) ? 8'($urandom) : lo_cfg[m_cyc]};
    end

    // One acknowledge: w1/w2 wait clocks, first/second cycle low bytes.
    task automatic run_ack(input int w1, input int w2, input logic [7:0] b1,
                           input logic [7:0] b2, input int hold);
        w_cfg[0] = w1; w_cfg[1] = w2; lo_cfg[0] = b1; lo_cfg[1] = b2;
        @(negedge clk);
        inta_cnt = 0; ale_cnt = 0;
        ack_req = 1'b1;
        repeat (hold) @(negedge clk);
        ack_req = 1'b0;
        while (!m_valid) @(negedge clk);
        #1;
        check("R5", "inta low clocks", inta_cnt, 4 + w1 + w2);
        check("R8", "ale pulses", ale_cnt, 2);
        check("R6", "vector byte", int'(vec), int'(b2));
        check("R7", "valid pulse", int'(vec_valid), 1);
        repeat (3) @(negedge clk);
        check("R7", "vector held", int'(vec), int'(b2));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        w_cfg[0] = 0; w_cfg[1] = 0; lo_cfg[0] = 8'h00; lo_cfg[1] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1", "reset inta_n", int'(inta_n), 1);
        check("R1", "reset lock", int'(lock), 0);
        check("R1", "reset ale", int'(ale), 0);
        check("R1", "reset valid", int'(vec_valid), 0);
        check("R1", "reset vec", int'(vec), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_ack(0, 0, 8'h11, 8'h5A, 1);
        run_ack(2, 0, 8'hA5, 8'h3C, 1);
        run_ack(0, 3, 8'hFF, 8'h00, 1);
        run_ack(4, 5, 8'h77, 8'hC3, 1);
        run_ack(1, 1, 8'h0F, 8'hF0, 6);
        // Request held into the valid clock is accepted at once (R8).
        w_cfg[0] = 0; w_cfg[1] = 0; lo_cfg[0] = 8'h12; lo_cfg[1] = 8'h81;
        @(negedge clk);
        ack_req = 1'b1;
        while (!m_valid) @(negedge clk);
        #1;
        check("R7", "valid first", int'(vec_valid), 1);
        @(negedge clk);
        ack_req = 1'b0;
        #1;
        check("R8", "restart ale", int'(ale), 1);
        while (!m_valid) @(negedge clk);
        #1;
        check("R6", "second vector", int'(vec), 8'h81);
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule